// File: doc/BRIEF.md
# Two-Wire Register Slave with Busy Polling

This block is the serial front end of a small nonvolatile register map. The map holds three 6-bit tap registers for variable resistors and a short user memory. A two-wire (I2C) master on the board reads and writes the map. The block samples SCL and SDA with its own system clock and cleans both lines through a synchronizer and a glitch filter. It then finds start, repeated start and stop conditions, shifts bytes in and out, and drives SDA only by pulling it low.

A transaction picks a location through an internal address counter. In a write, the first byte after the device byte loads the counter, and each data byte after that lands at the counter, which then moves on. A read begins wherever the counter points. To read from a chosen location, the master writes only the location byte, sends a repeated start and then reads. When a stop ends a write that carried data, the block spends a fixed number of clocks committing the data to its nonvolatile page. For that whole time it stays silent to its own device address, so the master can keep addressing it until it gets an ACK.

The block carries no data stream of its own, so it has no valid/ready port. The only flow control is the one the bus protocol provides: the ACK and NACK bits, and the busy period during which the device address gets no ACK.

Top module: `nvreg_i2c_slave`

## Requirements
- R1: The block ACKs a device byte (SDA low during the ninth SCL pulse) only when bits [7:1] equal binary 1010 followed by `strap_addr[2:0]`. It leaves all other device bytes unanswered. Bit 0 selects the direction: 1 means read.
- R2: In a write, the byte after the device byte loads the 8-bit address counter. Each following data byte is stored at the counter, and the counter then moves up by one, wrapping from FFh to 00h.
- R3: A read that has no location byte before it returns data starting at the current counter. Each byte sent moves the counter up by one.
- R4: A location-only write, then a repeated start, then a device byte with bit 0 = 1, returns data starting at the chosen location.
- R5: During a read, a master ACK makes the block send the next byte. After a master NACK the block releases SDA, and it drives nothing until the next start.
- R6: A stop after a write that stored at least one data byte starts a busy period of COMMIT_CYCLES clocks. During that period no device byte is ACKed. A write that carried only a location byte starts no busy period.
- R7: Writing one byte of a 2-byte page leaves the other byte of that page, and every other location, at its previous value.
- R8: Tap registers sit at F8h, F9h and FAh. Each stores the low 6 bits of the written byte, and bits 7:6 read back as 0.
- R9: User memory occupies 00h up to USER_BYTES-1. Every other location reads 00h, and writes to it change nothing.
- R10: A start or repeated start in the middle of a byte abandons that byte, and the next eight bits are taken as a device byte.
- R11: After reset SDA is released, the counter is 00h and every location reads 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Level seen on the SCL wire |
| sda_in | input | 1 | Level seen on the SDA wire |
| strap_addr | input | 3 | Board straps that form the low three device-address bits |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it (open-drain enable) |

## Verification
On every cycle, the bound checker enforces several rules. SDA is driven only during an ACK bit or a sent byte, and it is released in idle. The device address is never ACKed while a commit is busy, and a busy period begins only at a stop. The counter moves only on an SCL falling edge. Tap locations read back with zero high bits, and unmapped locations read back as zero. The bench scenarios cover the rest:
- the sweep of all eight strap addresses;
- a 48-byte write that wraps the counter and crosses the unmapped, tap and user regions, then a full 256-byte read-back;
- timing of the busy period by polling;
- page-neighbour preservation;
- current-address reads;
- a start that cuts a byte short.

// File: rtl/nvreg_pkg.sv
`timescale 1ns/1ps
package nvreg_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_ACK,
    PH_TX,
    PH_MACK
  } phase_t;

  typedef enum logic [1:0] {
    BK_DEV,
    BK_PTR,
    BK_DATA
  } byte_kind_t;

  localparam logic [3:0] DEV_FAMILY = 4'b1010;
endpackage

// File: rtl/nvreg_line_filter.sv
`timescale 1ns/1ps
module nvreg_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic clean
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          run_q;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  // synchronizer chain, idle bus level is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
  end

  // the output follows only a level that has held for HOLD_CYCLES samples
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clean <= 1'b1;
      run_q <= '0;
    end else if (synced == clean) begin
      run_q <= '0;
    end else if (run_q == CW'(HOLD_CYCLES - 1)) begin
      clean <= synced;
      run_q <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/nvreg_bus_events.sv
`timescale 1ns/1ps
module nvreg_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl;
      sda_prev <= sda;
    end
  end

  assign scl_rise  = scl & ~scl_prev;
  assign scl_fall  = ~scl & scl_prev;
  // data edges while the clock stays high mark the frame boundaries
  assign start_evt = scl & scl_prev & sda_prev & ~sda;
  assign stop_evt  = scl & scl_prev & ~sda_prev & sda;
endmodule

// File: rtl/nvreg_store.sv
`timescale 1ns/1ps
module nvreg_store #(
  parameter int         USER_BYTES    = 16,
  parameter int         WIPER_COUNT   = 3,
  parameter logic [7:0] WIPER_BASE    = 8'hF8,
  parameter int         TAP_BITS      = 6,
  parameter int         COMMIT_CYCLES = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [7:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       commit_go,
  output logic       busy
);
  localparam int UAW = (USER_BYTES > 1) ? $clog2(USER_BYTES) : 1;
  localparam int TW  = $clog2(COMMIT_CYCLES + 1);

  logic [7:0]          user_q  [USER_BYTES];
  logic [TAP_BITS-1:0] wiper_q [WIPER_COUNT];
  logic [TW-1:0]       timer_q;
  logic                unused_hi;

  assign unused_hi = ^wr_data[7:TAP_BITS];

  // write-through storage; a byte outside both regions is dropped
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < USER_BYTES; i++) user_q[i] <= '0;
      for (int w = 0; w < WIPER_COUNT; w++) wiper_q[w] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < USER_BYTES; i++)
        if (int'(wr_addr) == i) user_q[i] <= wr_data;
      for (int w = 0; w < WIPER_COUNT; w++)
        if (wr_addr == WIPER_BASE + 8'(w)) wiper_q[w] <= wr_data[TAP_BITS-1:0];
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (int'(rd_addr) < USER_BYTES) rd_data = user_q[rd_addr[UAW-1:0]];
    for (int w = 0; w < WIPER_COUNT; w++)
      if (rd_addr == WIPER_BASE + 8'(w))
        rd_data = {{(8-TAP_BITS){1'b0}}, wiper_q[w]};
  end

  // page commit timer: the device is busy while it runs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               timer_q <= '0;
    else if (commit_go)       timer_q <= TW'(COMMIT_CYCLES);
    else if (timer_q != '0)   timer_q <= timer_q - 1'b1;
  end

  assign busy = (timer_q != '0);
endmodule

// File: rtl/nvreg_i2c_slave.sv
`timescale 1ns/1ps
module nvreg_i2c_slave #(
  parameter int         USER_BYTES    = 16,
  parameter int         WIPER_COUNT   = 3,
  parameter logic [7:0] WIPER_BASE    = 8'hF8,
  parameter int         TAP_BITS      = 6,
  parameter int         COMMIT_CYCLES = 50000,
  parameter int         SYNC_STAGES   = 2,
  parameter int         HOLD_CYCLES   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [2:0] strap_addr,
  output logic       sda_pull
);
  import nvreg_pkg::*;

  localparam int LINES = 2;

  logic [LINES-1:0] raw_lines, clean_lines;
  logic scl_c, sda_c;
  logic scl_rise, scl_fall, start_evt, stop_evt;

  assign raw_lines = {sda_in, scl_in};

  for (genvar i = 0; i < LINES; i++) begin : g_line
    nvreg_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .HOLD_CYCLES(HOLD_CYCLES)
    ) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (raw_lines[i]),
      .clean(clean_lines[i])
    );
  end

  assign scl_c = clean_lines[0];
  assign sda_c = clean_lines[1];

  nvreg_bus_events u_events (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl      (scl_c),
    .sda      (sda_c),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt)
  );

  phase_t     phase_q;
  byte_kind_t kind_q;
  logic [3:0] bit_cnt_q;
  logic [7:0] shift_q;
  logic [7:0] ptr_q;
  logic       is_read_q;
  logic       more_q;
  logic       wrote_q;

  logic       wr_en, commit_go, busy, dev_match, byte_done;
  logic [7:0] rd_data;

  nvreg_store #(
    .USER_BYTES   (USER_BYTES),
    .WIPER_COUNT  (WIPER_COUNT),
    .WIPER_BASE   (WIPER_BASE),
    .TAP_BITS     (TAP_BITS),
    .COMMIT_CYCLES(COMMIT_CYCLES)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (ptr_q),
    .wr_data  (shift_q),
    .rd_addr  (ptr_q),
    .rd_data  (rd_data),
    .commit_go(commit_go),
    .busy     (busy)
  );

  assign byte_done = (phase_q == PH_RX) && scl_fall && (bit_cnt_q == 4'd8);
  assign dev_match = (shift_q[7:1] == {DEV_FAMILY, strap_addr}) && !busy;
  assign wr_en     = byte_done && (kind_q == BK_DATA) && !start_evt && !stop_evt;
  assign commit_go = stop_evt && wrote_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      kind_q    <= BK_DEV;
      bit_cnt_q <= '0;
      shift_q   <= '0;
      ptr_q     <= '0;
      is_read_q <= 1'b0;
      more_q    <= 1'b0;
      wrote_q   <= 1'b0;
    end else if (start_evt) begin
      phase_q   <= PH_RX;
      kind_q    <= BK_DEV;
      bit_cnt_q <= '0;
    end else if (stop_evt) begin
      phase_q   <= PH_IDLE;
      wrote_q   <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_RX: begin
          if (scl_rise && bit_cnt_q != 4'd8) begin
            shift_q   <= {shift_q[6:0], sda_c};
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end else if (byte_done) begin
            unique case (kind_q)
              BK_DEV: begin
                if (dev_match) begin
                  phase_q   <= PH_ACK;
                  is_read_q <= shift_q[0];
                end else begin
                  phase_q   <= PH_IDLE;
                end
              end
              BK_PTR: begin
                ptr_q   <= shift_q;
                phase_q <= PH_ACK;
              end
              default: begin
                ptr_q   <= ptr_q + 8'd1;
                wrote_q <= 1'b1;
                phase_q <= PH_ACK;
              end
            endcase
          end
        end
        PH_ACK: begin
          if (scl_fall) begin
            bit_cnt_q <= '0;
            if (is_read_q) begin
              shift_q <= rd_data;
              ptr_q   <= ptr_q + 8'd1;
              phase_q <= PH_TX;
            end else begin
              phase_q <= PH_RX;
              kind_q  <= (kind_q == BK_DEV) ? BK_PTR : BK_DATA;
            end
          end
        end
        PH_TX: begin
          if (scl_fall) begin
            if (bit_cnt_q == 4'd7) begin
              phase_q <= PH_MACK;
            end else begin
              shift_q   <= {shift_q[6:0], 1'b0};
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end
          end
        end
        PH_MACK: begin
          if (scl_rise) more_q <= !sda_c;
          if (scl_fall) begin
            if (more_q) begin
              shift_q   <= rd_data;
              ptr_q     <= ptr_q + 8'd1;
              bit_cnt_q <= '0;
              phase_q   <= PH_TX;
            end else begin
              phase_q <= PH_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_pull = (phase_q == PH_ACK) || ((phase_q == PH_TX) && !shift_q[7]);
endmodule

// File: rtl/nvreg_i2c_checker.sv
`timescale 1ns/1ps
module nvreg_i2c_checker #(
  parameter int         USER_BYTES  = 16,
  parameter int         WIPER_COUNT = 3,
  parameter logic [7:0] WIPER_BASE  = 8'hF8,
  parameter int         TAP_BITS    = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input nvreg_pkg::phase_t    phase,
  input nvreg_pkg::byte_kind_t kind,
  input logic                 sda_pull,
  input logic                 busy,
  input logic                 stop_evt,
  input logic                 scl_fall,
  input logic [7:0]           ptr,
  input logic [7:0]           rd_data
);
  import nvreg_pkg::*;

  logic in_user, in_wiper;
  assign in_user  = int'(ptr) < USER_BYTES;
  assign in_wiper = (int'(ptr) >= int'(WIPER_BASE)) &&
                    (int'(ptr) < int'(WIPER_BASE) + WIPER_COUNT);

  a_r5_idle_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !sda_pull);

  a_r11_pull_only_owned: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull |-> (phase == PH_ACK || phase == PH_TX));

  a_r6_silent_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ACK && kind == BK_DEV) |-> !busy);

  a_r6_busy_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_evt));

  a_r2_ptr_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptr) |-> $past(scl_fall));

  a_r8_tap_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_wiper |-> ((rd_data >> TAP_BITS) == 8'h00));

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_user && !in_wiper) |-> (rd_data == 8'h00));
endmodule

bind nvreg_i2c_slave nvreg_i2c_checker #(
  .USER_BYTES (USER_BYTES),
  .WIPER_COUNT(WIPER_COUNT),
  .WIPER_BASE (WIPER_BASE),
  .TAP_BITS   (TAP_BITS)
) u_check (
  .clk     (clk),
  .rst_n   (rst_n),
  .phase   (phase_q),
  .kind    (kind_q),
  .sda_pull(sda_pull),
  .busy    (busy),
  .stop_evt(stop_evt),
  .scl_fall(scl_fall),
  .ptr     (ptr_q),
  .rd_data (rd_data)
);

// File: tb/nvreg_i2c_slave_test.sv
`timescale 1ns/1ps
module nvreg_i2c_slave_test;
  localparam int COMMIT = 1500;
  localparam int Q      = 10;
  localparam int USERN  = 16;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEVW = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEVR = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic m_pull = 1'b0;
  logic sda_pull;
  logic sda_bus;
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   done = 0;
  logic [7:0] model [256];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign sda_bus = !(m_pull || sda_pull);

  nvreg_i2c_slave #(.USER_BYTES(USERN), .COMMIT_CYCLES(COMMIT)) uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
    .strap_addr(STRAP), .sda_pull(sda_pull)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_pull = 0; scl_m = 1; tick(Q);
    m_pull = 1; tick(Q);
    scl_m = 0; tick(Q);
  endtask

  task automatic bus_restart();
    m_pull = 0; tick(Q);
    scl_m = 1; tick(Q);
    m_pull = 1; tick(Q);
    scl_m = 0; tick(Q);
  endtask

  task automatic bus_stop();
    m_pull = 1; tick(Q);
    scl_m = 1; tick(Q);
    m_pull = 0; tick(Q);
  endtask

  task automatic clock_bit(input logic b, output logic seen);
    m_pull = !b; tick(Q);
    scl_m = 1; tick(Q);
    seen = sda_bus; tick(Q);
    scl_m = 0; tick(Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
    clock_bit(1'b1, s);
    acked = !s;
  endtask

  task automatic get_byte(output logic [7:0] b, input logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, s);
      b[i] = s;
    end
    m_pull = ack; tick(Q);
    scl_m = 1; tick(2*Q);
    scl_m = 0; tick(Q);
    m_pull = 0;
  endtask

  function automatic void model_write(input logic [7:0] a, input logic [7:0] v);
    if (int'(a) < USERN) model[a] = v;
    else if (a >= 8'hF8 && a <= 8'hFA) model[a] = v & 8'h3F;
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    if (int'(a) < USERN) return "R2";
    if (a >= 8'hF8 && a <= 8'hFA) return "R8";
    return "R9";
  endfunction

  task automatic wait_ready(output int polls);
    logic ack;
    polls = 0;
    do begin
      bus_start(); put_byte(DEVW, ack); bus_stop();
      polls++;
    end while (!ack && polls < 100);
  endtask

  task automatic write_bytes(input logic [7:0] a, input int n, input logic [7:0] v0, input string req);
    logic ack;
    logic [7:0] v;
    int polls;
    bus_start();
    put_byte(DEVW, ack);  check(ack, req, ack, 1);
    put_byte(a, ack);
    for (int i = 0; i < n; i++) begin
      v = v0 + 8'(i * 29);
      put_byte(v, ack);
      model_write(a + 8'(i), v);
    end
    bus_stop();
    wait_ready(polls);
  endtask

  task automatic read_from(input logic [7:0] a, input int n, input string req);
    logic ack;
    logic [7:0] d;
    bus_start();
    put_byte(DEVW, ack);
    put_byte(a, ack);
    bus_restart();
    put_byte(DEVR, ack);
    check(ack, {req, " read ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      get_byte(d, i != n - 1);
      check(d == model[a + 8'(i)],
            (req == "") ? tag_of(a + 8'(i)) : req, d, model[a + 8'(i)]);
    end
    bus_stop();
  endtask

  initial begin
    logic ack;
    logic [7:0] d;
    logic s;
    int polls, t0;
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    tick(10);
    rst_n = 1;
    tick(10);
    // R11: released line, counter at zero, storage empty
    check(sda_pull == 1'b0, "R11 sda", sda_pull, 0);
    bus_start(); put_byte(DEVR, ack);
    get_byte(d, 1'b0); bus_stop();
    check(d == 8'h00, "R11 first read", d, 0);

    // R1: sweep the eight strap codes of the family plus a foreign family
    for (int a = 0; a < 8; a++) begin
      bus_start(); put_byte({4'b1010, 3'(a), 1'b0}, ack); bus_stop();
      check(ack == (a == int'(STRAP)), "R1 strap sweep", ack, a == int'(STRAP));
    end
    bus_start(); put_byte({4'b0110, STRAP, 1'b0}, ack); bus_stop();
    check(!ack, "R1 foreign family", ack, 0);

    // R2/R8/R9: 48 bytes from F0h, wrapping into user memory
    bus_start(); put_byte(DEVW, ack); put_byte(8'hF0, ack);
    for (int i = 0; i < 48; i++) begin
      d = 8'(i * 29 + 7);
      put_byte(d, ack);
      model_write(8'hF0 + 8'(i), d);
    end
    bus_stop();
    t0 = cyc;
    // R6: busy period by polling
    wait_ready(polls);
    check(polls > 1, "R6 first poll not acked", polls, 2);
    check((cyc - t0) >= COMMIT && (cyc - t0) <= COMMIT + 1000,
          "R6 busy length", cyc - t0, COMMIT);

    // R4: full sweep read from 00h through the wrap
    read_from(8'h00, 256, "");

    // R5: NACK releases the line
    bus_start(); put_byte(DEVW, ack); put_byte(8'hF9, ack);
    bus_restart(); put_byte(DEVR, ack);
    get_byte(d, 1'b0);
    check(d == model[8'hF9], "R4 random read", d, model[8'hF9]);
    tick(Q);
    check(sda_pull == 1'b0, "R5 released after nack", sda_pull, 0);
    clock_bit(1'b1, s);
    check(s == 1'b1, "R5 silent until start", s, 1);
    bus_stop();

    // R7: single byte on a page keeps its neighbour
    write_bytes(8'h04, 1, 8'hA5, "R7");
    read_from(8'h03, 3, "R7");

    // R6: location-only write starts no commit; R3 current reads
    bus_start(); put_byte(DEVW, ack); put_byte(8'h0A, ack); bus_stop();
    wait_ready(polls);
    check(polls == 1, "R6 no commit without data", polls, 1);
    bus_start(); put_byte(DEVR, ack); get_byte(d, 1'b0); bus_stop();
    check(d == model[8'h0A], "R3 current read", d, model[8'h0A]);
    bus_start(); put_byte(DEVR, ack); get_byte(d, 1'b1); get_byte(s ? d : d, 1'b0); bus_stop();
    check(d == model[8'h0C], "R3 counter advanced", d, model[8'h0C]);

    // R10: start cutting a byte short
    bus_start();
    for (int i = 0; i < 4; i++) clock_bit(1'b0, s);
    bus_restart();
    put_byte(DEVW, ack);
    check(ack, "R10 device after abort", ack, 1);
    put_byte(8'h07, ack); put_byte(8'h3C, ack); bus_stop();
    model_write(8'h07, 8'h3C);
    wait_ready(polls);
    read_from(8'h07, 1, "R10");

    // R8: high bits dropped; R9: unmapped write ignored
    write_bytes(8'hFA, 1, 8'hC5, "R8");
    read_from(8'hFA, 1, "R8");
    write_bytes(8'h40, 1, 8'h77, "R9");
    read_from(8'h40, 1, "R9");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule